// File: doc/BRIEF.md
# Data Cache Maintenance Unit

This block carries out maintenance commands on a two-way set-associative write-back data cache whose tag and data arrays it holds itself. Each line is 64 bytes wide and has a tag with four flag bits: valid, dirty, a replacement hint and lock. Software-visible maintenance is driven through a single command port. Each command carries a 5-bit operation code, a 32-bit effective address and a 32-bit tag-transfer register value. The block reports completion with a one-cycle done pulse and returns the updated tag-transfer value.

There are two ways to choose the line a command acts on. Hit-addressed commands compare the address tag against both ways of the indexed set. Index-addressed commands name the way directly through address bit 0. Dirty lines that must reach memory leave on a full-line write-back port, which holds a request until it is acknowledged. The tag-transfer commands move either a line's tag and flags or one 32-bit data word between the arrays and the transfer register. Software uses these commands to seed, inspect, flush and drop lines.

Top module: `dcache_maint_unit`

## Requirements
- R1: After reset every line is invalid with all flags and tag zero, `cmd_ready_o` is high, `done_o`, `err_o` and `wb_req_o` are low and `taglo_o` is zero.
- R2: Index-addressed commands select the set from address bits [11:6] and the way from address bit 0. Data-word commands select the 32-bit word from address bits [5:2].
- R3: Transfer-register layout: bits [31:12] hold the tag and bits [11:4] read as zero. The flags occupy bits [3:0]: bit 3 lock, bit 2 replacement hint, bit 1 dirty, bit 0 valid. Code 0x12 writes the selected line's tag and all four flags from the command value. Code 0x10 returns them in `taglo_o`.
- R4: Code 0x13 writes the command value into the selected data word, and code 0x11 returns that word in `taglo_o`.
- R5: Code 0x1A (hit-invalidate) invalidates a hitting line without any write-back. A miss changes nothing. Invalidation clears the valid, dirty and lock flags and keeps the tag and the replacement hint.
- R6: Code 0x18 (hit-write-back-invalidate) first writes back a hitting line that is dirty and valid, then invalidates it.
- R7: Code 0x1C (hit-write-back) writes back a hitting dirty valid line. The line stays valid with its dirty flag cleared.
- R8: Code 0x16 (index-invalidate) invalidates the selected line without a write-back, even when that line is dirty.
- R9: Code 0x14 (index-write-back-invalidate) writes back the selected line if it is dirty and valid, then invalidates it.
- R10: Code 0x10 writes back a dirty valid line before it returns the tag. The returned flags show dirty cleared.
- R11: A write-back happens only when a line's dirty and valid flags are both set. The write-back address is {tag, set, 6'b0}, and data word k sits at `wb_data_o[32k+31:32k]`.
- R12: A command is accepted only while `cmd_ready_o` is high. Without a write-back, `done_o` rises in the cycle after acceptance. With a write-back, `wb_req_o` rises in the second cycle and `done_o` is high in the cycle where `wb_ack_i` is high. `taglo_o` is updated by the edge that ends that cycle.
- R13: Codes 0x07 and 0x0C complete in one cycle with no state change and no error. Any other code outside the supported set also completes in one cycle with no state change, and raises `err_o` together with `done_o`.
- R14: While `wb_req_o` is high and not yet acknowledged, it stays high and both `wb_addr_o` and `wb_data_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit idle, command may be accepted |
| cmd_op_i | input | 5 | Operation code |
| cmd_addr_i | input | 32 | Effective address |
| cmd_taglo_i | input | 32 | Tag-transfer register value in |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | Unsupported code, valid with done |
| taglo_o | output | 32 | Tag-transfer register value out |
| wb_req_o | output | 1 | Line write-back request |
| wb_ack_i | input | 1 | Line write-back acknowledge |
| wb_addr_o | output | 32 | Line write-back address |
| wb_data_o | output | 512 | Line write-back data |

## Verification
The bench targets lines that are dirty but invalid, and a hit on one way while the other way is resident in the same set. A design that tested only the dirty flag would issue a spurious write-back in the first case; one that picked the wrong way would flush or drop the neighbour line in the second. The bench checks that an invalidation keeps the replacement hint and tag while clearing lock. If all flags were cleared, or none, the following tag load would return the wrong flags. It also holds the acknowledge back for several cycles, so a unit that signalled done early or let the write-back address move would be caught. Finally, unsupported codes are issued and the target line is read back afterwards to show that it was not disturbed.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  localparam logic [4:0] OP_LD_TAG = 5'h10;
  localparam logic [4:0] OP_LD_DAT = 5'h11;
  localparam logic [4:0] OP_ST_TAG = 5'h12;
  localparam logic [4:0] OP_ST_DAT = 5'h13;
  localparam logic [4:0] OP_IX_WBI = 5'h14;
  localparam logic [4:0] OP_IX_INV = 5'h16;
  localparam logic [4:0] OP_HT_WBI = 5'h18;
  localparam logic [4:0] OP_HT_INV = 5'h1A;
  localparam logic [4:0] OP_HT_WB  = 5'h1C;
  localparam logic [4:0] OP_NOP_IC = 5'h07;
  localparam logic [4:0] OP_NOP_BT = 5'h0C;

  // Line flags; packed order matches transfer-register bits [3:0]
  typedef struct packed {
    logic lock;
    logic lrf;
    logic dirty;
    logic valid;
  } flags_t;

  typedef struct packed {
    logic hit_addr;  // line chosen by tag compare
    logic inval;     // line dropped at completion
    logic wb_ok;     // dirty valid line is written back first
    logic ld_tag;
    logic st_tag;
    logic ld_dat;
    logic st_dat;
    logic bad;       // unsupported code
  } dec_t;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WB} st_e;

endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
  import dcm_pkg::*;
(
  input  logic [4:0] op_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o = '0;
    case (op_i)
      OP_HT_INV: begin dec_o.hit_addr = 1'b1; dec_o.inval = 1'b1; end
      OP_HT_WBI: begin dec_o.hit_addr = 1'b1; dec_o.inval = 1'b1; dec_o.wb_ok = 1'b1; end
      OP_HT_WB:  begin dec_o.hit_addr = 1'b1; dec_o.wb_ok = 1'b1; end
      OP_IX_INV: dec_o.inval = 1'b1;
      OP_IX_WBI: begin dec_o.inval = 1'b1; dec_o.wb_ok = 1'b1; end
      OP_LD_TAG: begin dec_o.ld_tag = 1'b1; dec_o.wb_ok = 1'b1; end
      OP_ST_TAG: dec_o.st_tag = 1'b1;
      OP_LD_DAT: dec_o.ld_dat = 1'b1;
      OP_ST_DAT: dec_o.st_dat = 1'b1;
      OP_NOP_IC, OP_NOP_BT: ;
      default:   dec_o.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store
  import dcm_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output flags_t [WAYS-1:0]           rd_flg_o,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  flags_t                      wr_flg_i
);

  localparam int ENTRIES = SETS * WAYS;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  flags_t           flg_q [ENTRIES];
  logic [IDX_W+WAY_W-1:0] wr_ptr;

  assign wr_ptr = {wr_idx_i, wr_way_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag_o[w] = tag_q[{rd_idx_i, WAY_W'(w)}];
    assign rd_flg_o[w] = flg_q[{rd_idx_i, WAY_W'(w)}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e] <= '0;
        flg_q[e] <= '0;
      end
    end else if (we_i) begin
      tag_q[wr_ptr] <= wr_tag_i;
      flg_q[wr_ptr] <= wr_flg_i;
    end
  end

endmodule

// File: rtl/dcm_data_store.sv
module dcm_data_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 2,
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [WAY_W-1:0]           way_i,
  output logic [WORDS-1:0][31:0]     line_o,
  input  logic                       we_i,
  input  logic [WRD_W-1:0]           wrd_i,
  input  logic [31:0]                wdata_i
);

  localparam int ENTRIES = SETS * WAYS;

  logic [WORDS-1:0][31:0] mem_q [ENTRIES];
  logic [IDX_W+WAY_W-1:0] ptr;

  assign ptr    = {idx_i, way_i};
  assign line_o = mem_q[ptr];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[ptr][wrd_i] <= wdata_i;
  end

endmodule

// File: rtl/dcache_maint_unit.sv
module dcache_maint_unit
  import dcm_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int WORDS     = LINE_BYTES / 4,
  localparam int WRD_W     = $clog2(WORDS),
  localparam int TAG_W     = 32 - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [4:0]        cmd_op_i,
  input  logic [31:0]       cmd_addr_i,
  input  logic [31:0]       cmd_taglo_i,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       taglo_o,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  output logic [31:0]       wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o
);

  st_e  st_q, st_d;
  logic [4:0]  op_q;
  logic [31:0] addr_q, tlo_q, taglo_q;
  logic        cap;
  dec_t        dec;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] atag;
  logic [WRD_W-1:0] wrd;
  logic [WAY_W-1:0] iway, hit_way, sel_way;

  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  flags_t [WAYS-1:0]          rd_flg;
  logic [WAYS-1:0]            hitv;
  logic                       hit_any, present, need_wb, fire;
  logic [TAG_W-1:0]           sel_tag;
  flags_t                     sel_flg, new_flg, wr_flg;
  logic [TAG_W-1:0]           wr_tag;
  logic                       tag_we, dat_we, tlo_en;
  logic [31:0]                tlo_d;
  logic [WORDS-1:0][31:0]     rd_line;
  logic                       unused_bits;

  // ---------------- command capture ----------------
  assign cmd_ready_o = (st_q == S_IDLE);
  assign cap         = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      tlo_q  <= '0;
    end else if (cap) begin
      op_q   <= cmd_op_i;
      addr_q <= cmd_addr_i;
      tlo_q  <= cmd_taglo_i;
    end
  end

  dcm_decode u_dec (.op_i(op_q), .dec_o(dec));

  assign idx  = addr_q[OFF_W +: IDX_W];
  assign atag = addr_q[31 -: TAG_W];
  assign wrd  = addr_q[2 +: WRD_W];
  assign iway = addr_q[WAY_W-1:0];
  assign unused_bits = ^{addr_q[1], tlo_q[31-TAG_W:4]};

  // ---------------- arrays ----------------
  dcm_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_i (idx),
    .rd_tag_o (rd_tag),
    .rd_flg_o (rd_flg),
    .we_i     (tag_we),
    .wr_idx_i (idx),
    .wr_way_i (sel_way),
    .wr_tag_i (wr_tag),
    .wr_flg_i (wr_flg)
  );

  dcm_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .idx_i   (idx),
    .way_i   (sel_way),
    .line_o  (rd_line),
    .we_i    (dat_we),
    .wrd_i   (wrd),
    .wdata_i (tlo_q)
  );

  // ---------------- line selection ----------------
  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign hitv[w] = rd_flg[w].valid && (rd_tag[w] == atag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitv[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit_any = |hitv;
  assign sel_way = dec.hit_addr ? hit_way : iway;
  assign present = dec.hit_addr ? hit_any : 1'b1;
  assign sel_tag = rd_tag[sel_way];
  assign sel_flg = rd_flg[sel_way];
  assign need_wb = dec.wb_ok && present && sel_flg.valid && sel_flg.dirty;

  // ---------------- sequencing ----------------
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (cap) st_d = S_EXEC;
      S_EXEC:  st_d = need_wb ? S_WB : S_IDLE;
      S_WB:    if (wb_ack_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign fire   = ((st_q == S_EXEC) && !need_wb) || ((st_q == S_WB) && wb_ack_i);
  assign done_o = fire;
  assign err_o  = (st_q == S_EXEC) && dec.bad;

  // ---------------- completion effects ----------------
  always_comb begin
    new_flg = sel_flg;
    if (need_wb) new_flg.dirty = 1'b0;
    if (dec.inval) begin
      new_flg.valid = 1'b0;
      new_flg.dirty = 1'b0;
      new_flg.lock  = 1'b0;
    end
  end

  assign tag_we = fire && present && (dec.inval || need_wb || dec.st_tag);
  assign wr_tag = dec.st_tag ? tlo_q[31 -: TAG_W] : sel_tag;
  assign wr_flg = dec.st_tag ? flags_t'(tlo_q[3:0]) : new_flg;
  assign dat_we = fire && dec.st_dat;

  assign tlo_en = fire && (dec.ld_tag || dec.ld_dat);
  assign tlo_d  = dec.ld_tag ? {sel_tag, {(32-TAG_W-4){1'b0}}, new_flg} : rd_line[wrd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      taglo_q <= '0;
    else if (tlo_en) taglo_q <= tlo_d;
  end
  assign taglo_o = taglo_q;

  // ---------------- write-back port ----------------
  assign wb_req_o  = (st_q == S_WB);
  assign wb_addr_o = {sel_tag, idx, {OFF_W{1'b0}}};
  assign wb_data_o = rd_line;

  // ---------------- assertions ----------------
  p_wb_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_addr_o) && $stable(wb_data_o)));

  p_wb_dirty_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o |-> (sel_flg.valid && sel_flg.dirty));

  p_done_then_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cmd_ready_o && !done_o));

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  p_err_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && !wb_req_o));

endmodule

// File: tb/sim_dcache_maint_unit.sv
module sim_dcache_maint_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, wb_ack;
  logic [4:0]  cmd_op;
  logic [31:0] cmd_addr, cmd_tlo;
  logic        cmd_ready, done, err, wb_req;
  logic [31:0] taglo, wb_addr;
  logic [511:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [19:0] mt [64][2];
  logic [3:0]  mf [64][2];
  logic [31:0] md [64][2][16];
  logic [31:0] exp_tlo;

  always #4 clk = ~clk;

  dcache_maint_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_taglo_i(cmd_tlo),
    .done_o(done), .err_o(err), .taglo_o(taglo),
    .wb_req_o(wb_req), .wb_ack_i(wb_ack),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  task automatic chk(string rq, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cmd(logic [4:0] op, logic [31:0] addr, logic [31:0] tlo, int dly, string rq);
    int idx = int'(addr[11:6]);
    int way = -1;
    bit hitop = (op == 5'h1A || op == 5'h18 || op == 5'h1C);
    bit invop = (op == 5'h1A || op == 5'h18 || op == 5'h16 || op == 5'h14);
    bit wbop  = (op == 5'h18 || op == 5'h1C || op == 5'h14 || op == 5'h10);
    bit known = (op inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h16, 5'h18, 5'h1A, 5'h1C});
    bit nop   = (op == 5'h07 || op == 5'h0C);
    bit xwb;
    logic [511:0] xline = '0;
    logic [31:0]  xaddr = '0;
    if (hitop) begin
      for (int w = 0; w < 2; w++)
        if (way < 0 && mf[idx][w][0] && mt[idx][w] == addr[31:12]) way = w;
    end else if (known) begin
      way = int'(addr[0]);
    end
    xwb = wbop && way >= 0 && mf[idx][way][1:0] == 2'b11;
    if (xwb) begin
      for (int k = 0; k < 16; k++) xline[32*k +: 32] = md[idx][way][k];
      xaddr = {mt[idx][way], addr[11:6], 6'b0};
    end

    @(negedge clk);
    chk({rq, " R12 ready before"}, cmd_ready, 1'b1);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_tlo = tlo;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({rq, " R12 busy"}, cmd_ready, 1'b0);
    if (xwb) begin
      chk({rq, " R12 no early done"}, {done, wb_req}, 2'b00);
      @(negedge clk);
      chk({rq, " R11 wb req"}, wb_req, 1'b1);
      chk({rq, " R11 wb addr"}, wb_addr, xaddr);
      chk({rq, " R11 wb data"}, wb_data, xline);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk({rq, " R14 held"}, {wb_req, done, wb_addr}, {2'b10, xaddr});
      end
      wb_ack = 1'b1;
      #1;
      chk({rq, " R12 done on ack"}, done, 1'b1);
      @(negedge clk);
      wb_ack = 1'b0;
      chk({rq, " R14 req drops"}, wb_req, 1'b0);
    end else begin
      chk({rq, " R12/R13 done err wb"}, {done, err, wb_req}, {1'b1, !(known || nop), 1'b0});
      @(negedge clk);
    end

    // reference update
    if (way >= 0) begin
      if (xwb) mf[idx][way][1] = 1'b0;
      if (invop) mf[idx][way] = mf[idx][way] & 4'b0100;
      if (op == 5'h12) begin mt[idx][way] = tlo[31:12]; mf[idx][way] = tlo[3:0]; end
      if (op == 5'h13) md[idx][way][addr[5:2]] = tlo;
      if (op == 5'h10) exp_tlo = {mt[idx][way], 8'h00, mf[idx][way]};
      if (op == 5'h11) exp_tlo = md[idx][way][addr[5:2]];
    end
    chk({rq, " after done"}, {cmd_ready, done, taglo}, {2'b10, exp_tlo});
  endtask

  function automatic logic [31:0] ia(int set, int wd, int way);
    return (32'(set) << 6) | (32'(wd) << 2) | 32'(way);
  endfunction

  task automatic fill(int set, int way, logic [19:0] tg, logic [3:0] fl, logic [31:0] seed);
    cmd(5'h12, ia(set, 0, way), {tg, 8'h00, fl}, 0, "R3 store tag");
    for (int k = 0; k < 16; k++)
      cmd(5'h13, ia(set, k, way), seed ^ (32'(k) * 32'h01010101), 0, "R4 store word");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 2; w++) begin
        mt[s][w] = '0; mf[s][w] = '0;
        for (int k = 0; k < 16; k++) md[s][w][k] = '0;
      end
    exp_tlo = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; wb_ack = 1'b0;
    cmd_op = '0; cmd_addr = '0; cmd_tlo = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {cmd_ready, done, err, wb_req, taglo}, {4'b1000, 32'h0});
    rst_n = 1'b1;

    // R1: arrays empty
    cmd(5'h1A, 32'hABCDE140, 32'h0, 0, "R1 miss after reset");
    cmd(5'h10, ia(63, 0, 1), 32'h0, 0, "R1 empty tag");

    // seed a set with both ways resident
    fill(5, 0, 20'hABCDE, 4'b0011, 32'hA5A50000);
    fill(5, 1, 20'h12345, 4'b0001, 32'h3C3C0000);
    cmd(5'h10, ia(5, 0, 1), 32'h0, 0, "R3 load clean tag");
    cmd(5'h11, ia(5, 7, 1), 32'h0, 0, "R4 R2 load word way1");
    cmd(5'h11, ia(5, 15, 0), 32'h0, 0, "R4 R2 load word way0");

    // R7: hit write-back keeps line
    cmd(5'h1C, 32'hABCDE140, 32'h0, 2, "R7 hit wb");
    cmd(5'h10, ia(5, 0, 0), 32'h0, 0, "R7 line stays clean");
    cmd(5'h1C, 32'hABCDE140, 32'h0, 0, "R7 clean line no wb");

    // R5: hit-invalidate on way1, neighbour untouched
    cmd(5'h12, ia(5, 0, 1), {20'h12345, 8'h00, 4'b1111}, 0, "R3 store tag all flags");
    cmd(5'h1A, 32'h12345144, 32'h0, 0, "R5 hit inval no wb");
    cmd(5'h10, ia(5, 0, 1), 32'h0, 0, "R5 hint and tag kept");
    cmd(5'h10, ia(5, 0, 0), 32'h0, 0, "R5 neighbour kept");
    cmd(5'h1A, 32'h77777140, 32'h0, 0, "R5 miss no change");
    cmd(5'h10, ia(5, 0, 0), 32'h0, 0, "R5 miss left line");

    // R6: hit wb-invalidate with lock and hint set
    cmd(5'h12, ia(5, 0, 0), {20'hABCDE, 8'h00, 4'b1111}, 0, "R3 store dirty lock");
    cmd(5'h18, 32'hABCDE17C, 32'h0, 0, "R6 hit wb inval");
    cmd(5'h10, ia(5, 0, 0), 32'h0, 0, "R6 invalidated");

    // R8 / R9 index operations
    fill(63, 1, 20'hFEDCB, 4'b0011, 32'h5A5A0000);
    cmd(5'h16, ia(63, 0, 1), 32'h0, 0, "R8 index inval dirty no wb");
    cmd(5'h10, ia(63, 0, 1), 32'h0, 0, "R8 flags cleared");
    cmd(5'h12, ia(63, 0, 1), {20'hFEDCB, 8'h00, 4'b0011}, 0, "R3 re-dirty");
    cmd(5'h14, ia(63, 0, 1), 32'h0, 3, "R9 index wb inval");
    cmd(5'h10, ia(63, 0, 1), 32'h0, 0, "R9 flags cleared");

    // R11: dirty but invalid never written back
    cmd(5'h12, ia(63, 0, 1), {20'hFEDCB, 8'h00, 4'b0010}, 0, "R11 dirty invalid");
    cmd(5'h14, ia(63, 0, 1), 32'h0, 0, "R11 no wb on invalid");
    cmd(5'h18, 32'hFEDCBFC0, 32'h0, 0, "R11 hit op misses invalid");

    // R10: tag load flushes first
    fill(12, 0, 20'h0F0F0, 4'b0111, 32'hC0DE0000);
    cmd(5'h10, ia(12, 0, 0), 32'h0, 1, "R10 load tag wb");
    cmd(5'h10, ia(12, 0, 0), 32'h0, 0, "R10 no second wb");

    // R13: unsupported and ignored codes
    cmd(5'h05, ia(12, 0, 0), 32'hFFFFFFFF, 0, "R13 bad code");
    cmd(5'h07, ia(12, 0, 0), 32'hFFFFFFFF, 0, "R13 icache code");
    cmd(5'h0C, ia(12, 0, 0), 32'hFFFFFFFF, 0, "R13 btb code");
    cmd(5'h1F, ia(12, 3, 0), 32'hFFFFFFFF, 0, "R13 bad code 2");
    cmd(5'h10, ia(12, 0, 0), 32'h0, 0, "R13 tag untouched");
    cmd(5'h11, ia(12, 3, 0), 32'h0, 0, "R13 word untouched");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule